// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block runs the two training phases of a DisplayPort link of one to four lanes without help from software. After a start pulse it checks the requested link rate and lane count. It then runs clock recovery with training pattern 1 and channel equalisation with training pattern 2. Every access to the sink's configuration registers goes out as a single request on an abstract AUX request port: write the training pattern, write the per-lane drive settings, or read the six-byte link status block. A transport outside this block carries the request and answers it with an acknowledge, an error flag and the read bytes.

Between requests the sequencer decodes the lane status nibbles. It also merges the sink's per-lane adjust requests into one drive setting, taking the largest swing and the largest pre-emphasis asked for. That setting is driven to every active lane of the local PHY. Clock recovery stops early when the maximum swing is already in use, or when the lane-0 swing has stayed the same for too many passes. Equalisation is limited to a fixed number of status reads. When the run ends, the block pulses `done` and holds a result code. The code tells apart a clean finish, a rejected configuration, an AUX error, a clock recovery failure and an equalisation failure.

Top module: `dp_link_trainer`

## Requirements
- R1: A start is rejected with result 2 and no AUX request is issued unless `linkRate` is 0x06 or 0x0A and `laneCount` is between 1 and 4.
- R2: An accepted start sets `phyPattern` to 1 and writes one byte 0x01 to sink address 0x102. It then writes the lane settings, all zero at first, to address 0x103 with a length equal to the lane count. An AUX request stays asserted with stable address and direction until it is acknowledged.
- R3: Status byte 0 holds lanes 0 and 1, and byte 1 holds lanes 2 and 3. Even lanes use the low nibble and odd lanes the high nibble. Clock recovery passes when bit 0 of every active lane's nibble is set. Nibbles of inactive lanes have no effect.
- R4: Adjust requests sit in status bytes 4 (lanes 0 and 1) and 5 (lanes 2 and 3). Each lane has swing in bits 1:0 and pre-emphasis in bits 3:2 of its nibble, laid out like the status nibbles. The new drive byte has swing in bits 1:0, a max-swing flag in bit 2, pre-emphasis in bits 4:3 and a max-pre-emphasis flag in bit 5. Each level is the maximum over the active lanes, and a flag is set when its level equals 3. The same byte goes to every active lane.
- R5: A clock recovery status read that fails while the max-swing flag is set in the current drive ends training with result 4.
- R6: Clock recovery ends with result 4 when the lane-0 swing has matched the previous pass's swing on 5 consecutive failing passes. A change of swing resets that count.
- R7: Equalisation sets `phyPattern` to 2, writes byte 0x02 to address 0x102 and writes no lane settings to the sink. It passes with result 1 only when bit 0 of status byte 2 is set and bits 2:0 of every active lane's nibble are all set.
- R8: Equalisation makes at most 5 status reads and then ends with result 5.
- R9: An acknowledge that carries the error flag ends training at once with result 3, and no further request follows.
- R10: `done` is a one-cycle pulse. `result` holds its value until the next accepted start. `phyPattern` is 0 whenever the block is not busy.
- R11: Each active lane's PHY control byte takes the current drive before the lane-setting write goes out. Inactive lanes read 0 from the start of a run onward.
- R12: Status reads use address 0x202 with a length of 6. Each read follows a settle wait of `CR_SETTLE` cycles in clock recovery or `EQ_SETTLE` cycles in equalisation, during which no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| linkRate | input | 8 | Link rate code to validate |
| laneCount | input | 3 | Number of lanes to train |
| auxReq | output | 1 | AUX request valid, held until acknowledge |
| auxWrite | output | 1 | 1 for a write, 0 for a read |
| auxAddr | output | 20 | Sink register address |
| auxLen | output | 4 | Number of bytes |
| auxWdata | output | 32 | Write bytes, byte k at bits 8k+7:8k |
| auxAck | input | 1 | Request completed |
| auxErr | input | 1 | Completed request failed, valid with auxAck |
| auxRdata | input | 48 | Read bytes, valid with auxAck |
| phyPattern | output | 2 | Training pattern driven to the local PHY |
| phyLaneCtl | output | 32 | Drive byte per lane, lane k at bits 8k+7:8k |
| busy | output | 1 | Training in progress |
| done | output | 1 | One-cycle end pulse |
| result | output | 3 | 1 ok, 2 bad config, 3 AUX error, 4 CR fail, 5 EQ fail |

## Verification
Several properties are checked on every cycle. A request stays held and stable until its acknowledge, and no request follows an erroring acknowledge. The end pulse lasts one cycle and the pattern is idle outside a run. Equalisation never makes more than five reads. The lane bytes are uniform across active lanes and zero on inactive ones, and a swing or pre-emphasis at level 3 always carries its flag. Other behaviour can only be shown by the directed scenarios that feed scripted status blocks: which request sequence and lane data come out, how adjust requests from several lanes merge, where clock recovery stops under a fixed or changing swing, and which result code each path ends with.

// File: rtl/dplt_pkg.sv
package dplt_pkg;
  localparam int MAX_LANES = 4;
  localparam logic [19:0] ADDR_PATTERN  = 20'h00102;
  localparam logic [19:0] ADDR_LANE_SET = 20'h00103;
  localparam logic [19:0] ADDR_STATUS   = 20'h00202;
  localparam logic [7:0]  RATE_LOW      = 8'h06;
  localparam logic [7:0]  RATE_HIGH     = 8'h0A;

  typedef enum logic [2:0] {
    RES_NONE    = 3'd0,
    RES_OK      = 3'd1,
    RES_BAD_CFG = 3'd2,
    RES_AUX_ERR = 3'd3,
    RES_CR_FAIL = 3'd4,
    RES_EQ_FAIL = 3'd5
  } result_t;

  // control -> datapath
  typedef struct packed {
    logic latchLanes;
    logic initCr;
    logic initEq;
    logic capture;
    logic adjust;
    logic applyPhy;
    logic armWait;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic waitDone;
    logic crOk;
    logic eqOk;
    logic maxSwing;
    logic crRetryOut;
    logic eqRetryOut;
  } dpFlags_t;
endpackage

// File: rtl/dplt_status_decode.sv
module dplt_status_decode
  import dplt_pkg::*;
(
  input  logic [15:0] laneStat,
  input  logic        alignDone,
  input  logic [15:0] adjReq,
  input  logic [2:0]  lanes,
  output logic        crOk,
  output logic        eqOk,
  output logic [7:0]  merged
);
  logic [1:0] swMax;
  logic [1:0] peMax;

  always_comb begin
    crOk  = 1'b1;
    eqOk  = alignDone;
    swMax = 2'd0;
    peMax = 2'd0;
    for (int k = 0; k < MAX_LANES; k++) begin
      if (k < int'(lanes)) begin
        if (!laneStat[4*k]) crOk = 1'b0;
        if (laneStat[4*k +: 3] != 3'b111) eqOk = 1'b0;
        if (adjReq[4*k +: 2] > swMax) swMax = adjReq[4*k +: 2];
        if (adjReq[4*k+2 +: 2] > peMax) peMax = adjReq[4*k+2 +: 2];
      end
    end
    merged = {2'b00, (peMax == 2'd3), peMax, (swMax == 2'd3), swMax};
  end
endmodule

// File: rtl/dplt_datapath.sv
module dplt_datapath
  import dplt_pkg::*;
#(
  parameter int CR_SETTLE = 1000,
  parameter int EQ_SETTLE = 400,
  parameter int CR_RETRY  = 5,
  parameter int EQ_RETRY  = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strb,
  input  logic [2:0]  laneCountIn,
  input  logic [47:0] auxRdata,
  output dpFlags_t    flags,
  output logic [7:0]  drive,
  output logic [2:0]  lanes,
  output logic [31:0] phyLaneCtl
);
  localparam int SMAX = (CR_SETTLE > EQ_SETTLE) ? CR_SETTLE : EQ_SETTLE;
  localparam int CW   = $clog2(SMAX + 1);
  localparam int TW   = $clog2(((CR_RETRY > EQ_RETRY) ? CR_RETRY : EQ_RETRY) + 1);

  logic [15:0]   laneStat;
  logic          alignDone;
  logic [15:0]   adjReq;
  logic [1:0]    lastSwing;
  logic          lastValid;
  logic [TW-1:0] crTries;
  logic [TW-1:0] eqTries;
  logic [CW-1:0] settleCnt;
  logic          eqPhase;
  logic [7:0]    merged;
  logic          crOk;
  logic          eqOk;

  dplt_status_decode u_dec (
    .laneStat (laneStat),
    .alignDone(alignDone),
    .adjReq   (adjReq),
    .lanes    (lanes),
    .crOk     (crOk),
    .eqOk     (eqOk),
    .merged   (merged)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lanes     <= '0;
      laneStat  <= '0;
      alignDone <= 1'b0;
      adjReq    <= '0;
      drive     <= '0;
      lastSwing <= '0;
      lastValid <= 1'b0;
      crTries   <= '0;
      eqTries   <= '0;
      eqPhase   <= 1'b0;
    end else begin
      if (strb.latchLanes) lanes <= laneCountIn;
      if (strb.initCr) begin
        drive     <= '0;
        lastValid <= 1'b0;
        crTries   <= '0;
        eqPhase   <= 1'b0;
      end
      if (strb.initEq) begin
        eqTries <= '0;
        eqPhase <= 1'b1;
      end
      if (strb.capture) begin
        laneStat  <= auxRdata[15:0];
        alignDone <= auxRdata[16];
        adjReq    <= auxRdata[47:32];
      end
      if (strb.adjust) begin
        if (eqPhase) begin
          eqTries <= eqTries + 1'b1;
        end else begin
          if (lastValid && (drive[1:0] == lastSwing)) crTries <= crTries + 1'b1;
          else crTries <= '0;
          lastSwing <= drive[1:0];
          lastValid <= 1'b1;
        end
        drive <= merged;
      end
    end
  end

  // settle timer
  always_ff @(posedge clk) begin
    if (!rstN) settleCnt <= '0;
    else if (strb.armWait) settleCnt <= eqPhase ? CW'(EQ_SETTLE - 1) : CW'(CR_SETTLE - 1);
    else if (settleCnt != '0) settleCnt <= settleCnt - 1'b1;
  end

  // per-lane PHY drive registers
  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN || strb.latchLanes) phyLaneCtl[8*g +: 8] <= '0;
      else if (strb.applyPhy) phyLaneCtl[8*g +: 8] <= (g < int'(lanes)) ? drive : 8'h00;
    end
  end

  assign flags.waitDone   = (settleCnt == '0);
  assign flags.crOk       = crOk;
  assign flags.eqOk       = eqOk;
  assign flags.maxSwing   = drive[2];
  assign flags.crRetryOut = lastValid && (drive[1:0] == lastSwing) && (crTries == TW'(CR_RETRY - 1));
  assign flags.eqRetryOut = (eqTries == TW'(EQ_RETRY - 1));
endmodule

// File: rtl/dplt_ctrl.sv
module dplt_ctrl
  import dplt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  linkRate,
  input  logic [2:0]  laneCount,
  input  logic        auxAck,
  input  logic        auxErr,
  input  dpFlags_t    flags,
  input  logic [7:0]  drive,
  input  logic [2:0]  lanes,
  output dpStrobe_t   strb,
  output logic        auxReq,
  output logic        auxWrite,
  output logic [19:0] auxAddr,
  output logic [3:0]  auxLen,
  output logic [31:0] auxWdata,
  output logic [1:0]  phyPattern,
  output logic        busy,
  output logic        done,
  output logic [2:0]  result
);
  typedef enum logic [3:0] {
    S_IDLE, S_CR_PAT, S_CR_APPLY, S_CR_SET, S_CR_WAIT, S_CR_READ, S_CR_EVAL,
    S_EQ_PAT, S_EQ_APPLY, S_EQ_WAIT, S_EQ_READ, S_EQ_EVAL, S_DONE
  } state_t;

  state_t  state, nextState;
  result_t res, nextRes;
  logic    cfgOk;
  logic    ackOk;

  assign cfgOk = ((linkRate == RATE_LOW) || (linkRate == RATE_HIGH)) &&
                 (laneCount != 3'd0) && (laneCount <= 3'(MAX_LANES));
  assign ackOk = auxAck && !auxErr;

  always_comb begin
    nextState = state;
    nextRes   = res;
    strb      = '0;
    unique case (state)
      S_IDLE: if (start) begin
        strb.latchLanes = 1'b1;
        if (cfgOk) begin
          strb.initCr = 1'b1;
          nextRes     = RES_NONE;
          nextState   = S_CR_PAT;
        end else begin
          nextRes   = RES_BAD_CFG;
          nextState = S_DONE;
        end
      end
      S_CR_PAT:   if (ackOk) nextState = S_CR_APPLY;
      S_CR_APPLY: begin
        strb.applyPhy = 1'b1;
        nextState     = S_CR_SET;
      end
      S_CR_SET: if (ackOk) begin
        strb.armWait = 1'b1;
        nextState    = S_CR_WAIT;
      end
      S_CR_WAIT: if (flags.waitDone) nextState = S_CR_READ;
      S_CR_READ: if (ackOk) begin
        strb.capture = 1'b1;
        nextState    = S_CR_EVAL;
      end
      S_CR_EVAL: begin
        if (flags.crOk) begin
          strb.initEq = 1'b1;
          nextState   = S_EQ_PAT;
        end else if (flags.maxSwing || flags.crRetryOut) begin
          nextRes   = RES_CR_FAIL;
          nextState = S_DONE;
        end else begin
          strb.adjust = 1'b1;
          nextState   = S_CR_APPLY;
        end
      end
      S_EQ_PAT:   if (ackOk) nextState = S_EQ_APPLY;
      S_EQ_APPLY: begin
        strb.applyPhy = 1'b1;
        strb.armWait  = 1'b1;
        nextState     = S_EQ_WAIT;
      end
      S_EQ_WAIT: if (flags.waitDone) nextState = S_EQ_READ;
      S_EQ_READ: if (ackOk) begin
        strb.capture = 1'b1;
        nextState    = S_EQ_EVAL;
      end
      S_EQ_EVAL: begin
        if (flags.eqOk) begin
          nextRes   = RES_OK;
          nextState = S_DONE;
        end else if (flags.eqRetryOut) begin
          nextRes   = RES_EQ_FAIL;
          nextState = S_DONE;
        end else begin
          strb.adjust = 1'b1;
          nextState   = S_EQ_APPLY;
        end
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
    // any failed AUX completion ends the run
    if (auxReq && auxAck && auxErr) begin
      strb.capture = 1'b0;
      strb.armWait = 1'b0;
      nextRes      = RES_AUX_ERR;
      nextState    = S_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      res        <= RES_NONE;
      phyPattern <= 2'd0;
    end else begin
      state <= nextState;
      res   <= nextRes;
      if (nextState == S_CR_PAT && state == S_IDLE) phyPattern <= 2'd1;
      else if (nextState == S_EQ_PAT && state == S_CR_EVAL) phyPattern <= 2'd2;
      else if (nextState == S_DONE) phyPattern <= 2'd0;
    end
  end

  always_comb begin
    auxReq   = 1'b0;
    auxWrite = 1'b1;
    auxAddr  = ADDR_PATTERN;
    auxLen   = 4'd1;
    auxWdata = 32'h0;
    unique case (state)
      S_CR_PAT: begin auxReq = 1'b1; auxWdata = 32'h01; end
      S_EQ_PAT: begin auxReq = 1'b1; auxWdata = 32'h02; end
      S_CR_SET: begin
        auxReq   = 1'b1;
        auxAddr  = ADDR_LANE_SET;
        auxLen   = {1'b0, lanes};
        auxWdata = {4{drive}};
      end
      S_CR_READ, S_EQ_READ: begin
        auxReq   = 1'b1;
        auxWrite = 1'b0;
        auxAddr  = ADDR_STATUS;
        auxLen   = 4'd6;
      end
      default: ;
    endcase
  end

  assign busy   = (state != S_IDLE);
  assign done   = (state == S_DONE);
  assign result = res;
endmodule

// File: rtl/dp_link_trainer.sv
module dp_link_trainer
  import dplt_pkg::*;
#(
  parameter int CR_SETTLE = 1000,
  parameter int EQ_SETTLE = 400,
  parameter int CR_RETRY  = 5,
  parameter int EQ_RETRY  = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  linkRate,
  input  logic [2:0]  laneCount,
  output logic        auxReq,
  output logic        auxWrite,
  output logic [19:0] auxAddr,
  output logic [3:0]  auxLen,
  output logic [31:0] auxWdata,
  input  logic        auxAck,
  input  logic        auxErr,
  input  logic [47:0] auxRdata,
  output logic [1:0]  phyPattern,
  output logic [31:0] phyLaneCtl,
  output logic        busy,
  output logic        done,
  output logic [2:0]  result
);
  dpStrobe_t  strb;
  dpFlags_t   flags;
  logic [7:0] drive;
  logic [2:0] lanes;

  dplt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .linkRate(linkRate), .laneCount(laneCount),
    .auxAck(auxAck), .auxErr(auxErr), .flags(flags), .drive(drive), .lanes(lanes),
    .strb(strb), .auxReq(auxReq), .auxWrite(auxWrite), .auxAddr(auxAddr),
    .auxLen(auxLen), .auxWdata(auxWdata), .phyPattern(phyPattern),
    .busy(busy), .done(done), .result(result)
  );

  dplt_datapath #(
    .CR_SETTLE(CR_SETTLE), .EQ_SETTLE(EQ_SETTLE),
    .CR_RETRY(CR_RETRY), .EQ_RETRY(EQ_RETRY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .laneCountIn(laneCount),
    .auxRdata(auxRdata), .flags(flags), .drive(drive), .lanes(lanes),
    .phyLaneCtl(phyLaneCtl)
  );
endmodule

// File: rtl/dplt_checker.sv
module dplt_checker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [2:0]  laneCount,
  input logic        auxReq,
  input logic        auxWrite,
  input logic [19:0] auxAddr,
  input logic        auxAck,
  input logic        auxErr,
  input logic [1:0]  phyPattern,
  input logic [31:0] phyLaneCtl,
  input logic        busy,
  input logic        done
);
  logic [2:0] lanesSeen;
  logic [3:0] eqReads;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lanesSeen <= '0;
      eqReads   <= '0;
    end else if (start && !busy) begin
      lanesSeen <= laneCount;
      eqReads   <= '0;
    end else if (auxReq && auxAck && !auxWrite && phyPattern == 2'd2) begin
      eqReads <= eqReads + 1'b1;
    end
  end

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (auxReq && !auxAck) |=> (auxReq && $stable(auxAddr) && $stable(auxWrite)));

  a_r9_quiet_after_err: assert property (@(posedge clk) disable iff (!rstN)
    (auxReq && auxAck && auxErr) |=> !auxReq);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_idle_pattern: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (phyPattern == 2'd0));

  a_r8_eq_read_limit: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (eqReads <= 4'd5));

  a_r4_swing_flag: assert property (@(posedge clk) disable iff (!rstN)
    (phyLaneCtl[1:0] == 2'd3) |-> phyLaneCtl[2]);

  a_r4_preemph_flag: assert property (@(posedge clk) disable iff (!rstN)
    (phyLaneCtl[4:3] == 2'd3) |-> phyLaneCtl[5]);

  for (genvar g = 1; g < 4; g++) begin : g_chk
    a_r11_inactive_zero: assert property (@(posedge clk) disable iff (!rstN)
      (busy && g >= int'(lanesSeen)) |-> (phyLaneCtl[8*g +: 8] == 8'h00));
    a_r4_uniform: assert property (@(posedge clk) disable iff (!rstN)
      (busy && g < int'(lanesSeen)) |-> (phyLaneCtl[8*g +: 8] == phyLaneCtl[7:0]));
  end
endmodule

bind dp_link_trainer dplt_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .laneCount(laneCount),
  .auxReq(auxReq), .auxWrite(auxWrite), .auxAddr(auxAddr), .auxAck(auxAck),
  .auxErr(auxErr), .phyPattern(phyPattern), .phyLaneCtl(phyLaneCtl),
  .busy(busy), .done(done)
);

// File: tb/sim_dp_link_trainer.sv
`timescale 1ns/1ps
module sim_dp_link_trainer;
  localparam int CRS = 16;
  localparam int EQS = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  linkRate = 8'h0A;
  logic [2:0]  laneCount = 3'd4;
  logic        auxReq, auxWrite;
  logic [19:0] auxAddr;
  logic [3:0]  auxLen;
  logic [31:0] auxWdata;
  logic        auxAck = 1'b0;
  logic        auxErr = 1'b0;
  logic [47:0] auxRdata = '0;
  logic [1:0]  phyPattern;
  logic [31:0] phyLaneCtl;
  logic        busy, done;
  logic [2:0]  result;

  always #4 clk = ~clk;

  dp_link_trainer #(.CR_SETTLE(CRS), .EQ_SETTLE(EQS)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .linkRate(linkRate), .laneCount(laneCount),
    .auxReq(auxReq), .auxWrite(auxWrite), .auxAddr(auxAddr), .auxLen(auxLen),
    .auxWdata(auxWdata), .auxAck(auxAck), .auxErr(auxErr), .auxRdata(auxRdata),
    .phyPattern(phyPattern), .phyLaneCtl(phyLaneCtl), .busy(busy), .done(done),
    .result(result)
  );

  int nChecks = 0;
  int nFail = 0;

  // sink model state and request log
  logic [47:0] statTab [16];
  int          errAt = -1;
  int          reqCnt = 0;
  int          readCnt = 0;
  logic [19:0] logAddr [64];
  logic        logWr   [64];
  logic [3:0]  logLen  [64];
  logic [31:0] logData [64];
  logic [31:0] logPhy  [64];
  int          waitGap = 0;
  int          lastReqEnd = 0;
  int          cyc = 0;
  int          setWrites = 0;
  logic        finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [47:0] st(input logic [7:0] b0, b1, b2, b4, b5);
    return {b5, b4, 8'h00, b2, b1, b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // responder: one request answered per ack
  initial begin
    forever begin
      @(negedge clk);
      if (auxAck) begin
        auxAck = 1'b0;
        auxErr = 1'b0;
        lastReqEnd = cyc;
      end else if (auxReq) begin
        if (reqCnt < 64) begin
          logAddr[reqCnt] = auxAddr;
          logWr[reqCnt]   = auxWrite;
          logLen[reqCnt]  = auxLen;
          logData[reqCnt] = auxWdata;
          logPhy[reqCnt]  = phyLaneCtl;
        end
        if (!auxWrite) begin
          if (cyc - lastReqEnd > waitGap) waitGap = cyc - lastReqEnd;
          auxRdata = statTab[readCnt < 16 ? readCnt : 15];
          readCnt++;
        end
        if (auxAddr == 20'h00103) setWrites++;
        auxErr = (reqCnt == errAt);
        auxAck = 1'b1;
        reqCnt++;
      end
    end
  end

  task automatic prep();
    for (int i = 0; i < 16; i++) statTab[i] = '0;
    errAt = -1; reqCnt = 0; readCnt = 0; setWrites = 0; waitGap = 0;
  endtask

  task automatic run(input logic [7:0] rate, input logic [2:0] lanes);
    int n;
    @(negedge clk);
    linkRate = rate; laneCount = lanes; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done === 1'b1, "R10 done seen", done, 1);
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", done, 0);
    chk(phyPattern == 2'd0, "R10 pattern idle", phyPattern, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !auxReq, "R10 reset idle", {busy, done, auxReq}, 0);
    chk(phyPattern == 0 && phyLaneCtl == 0, "R10 reset phy", phyLaneCtl, 0);
  endtask

  task automatic t_bad_cfg();
    prep(); run(8'h14, 3'd4);
    chk(result == 3'd2, "R1 bad rate", result, 2);
    prep(); run(8'h0A, 3'd0);
    chk(result == 3'd2, "R1 zero lanes", result, 2);
    prep(); run(8'h06, 3'd5);
    chk(result == 3'd2, "R1 five lanes", result, 2);
    chk(reqCnt == 0, "R1 no aux", reqCnt, 0);
  endtask

  task automatic t_happy();
    prep();
    statTab[0] = st(8'h11, 8'h11, 8'h00, 8'h00, 8'h00);
    statTab[1] = st(8'h77, 8'h77, 8'h01, 8'h00, 8'h00);
    run(8'h0A, 3'd4);
    chk(result == 3'd1, "R7 pass result", result, 1);
    chk(reqCnt == 5, "R7 request count", reqCnt, 5);
    chk(logAddr[0] == 20'h102 && logWr[0] && logLen[0] == 1 && logData[0][7:0] == 8'h01,
        "R2 pattern1 write", logData[0], 1);
    chk(logAddr[1] == 20'h103 && logLen[1] == 4 && logData[1] == 0, "R2 zero drive write",
        {logLen[1], logData[1]}, 64'h4_00000000);
    chk(logAddr[2] == 20'h202 && !logWr[2] && logLen[2] == 6, "R12 status read",
        {logAddr[2], logLen[2]}, {20'h202, 4'd6});
    chk(logAddr[3] == 20'h102 && logData[3][7:0] == 8'h02, "R7 pattern2 write", logData[3], 2);
    chk(setWrites == 1, "R7 no lane write in eq", setWrites, 1);
    chk(waitGap >= EQS, "R12 settle gap", waitGap, EQS);
  endtask

  task automatic t_merge();
    prep();
    statTab[0] = st(8'h01, 8'h00, 8'h00, 8'h29, 8'hFF);
    statTab[1] = st(8'h11, 8'h00, 8'h00, 8'h00, 8'h00);
    statTab[2] = st(8'h77, 8'h00, 8'h01, 8'h00, 8'h00);
    run(8'h06, 3'd2);
    chk(result == 3'd1, "R3 inactive lanes ignored", result, 1);
    chk(logAddr[3] == 20'h103 && logLen[3] == 2 && logData[3][15:0] == 16'h1212,
        "R4 merged drive", logData[3][15:0], 16'h1212);
    chk(logPhy[3] == 32'h00001212, "R11 phy lanes", logPhy[3], 32'h00001212);
    chk(phyLaneCtl == 32'h00001212, "R11 phy held", phyLaneCtl, 32'h00001212);
  endtask

  task automatic t_max_swing();
    prep();
    statTab[0] = st(8'h00, 8'h00, 8'h00, 8'h0F, 8'h00);
    statTab[1] = st(8'h00, 8'h00, 8'h00, 8'h0F, 8'h00);
    run(8'h0A, 3'd1);
    chk(logData[3][7:0] == 8'h3F, "R4 max flags", logData[3][7:0], 8'h3F);
    chk(result == 3'd4, "R5 max swing fail", result, 4);
    chk(readCnt == 2, "R5 read count", readCnt, 2);
  endtask

  task automatic t_retry();
    prep();
    run(8'h0A, 3'd1);
    chk(result == 3'd4, "R6 same swing fail", result, 4);
    chk(readCnt == 6, "R6 reads before stop", readCnt, 6);
    prep();
    for (int i = 2; i < 16; i++) statTab[i] = st(8'h00, 8'h00, 8'h00, 8'h01, 8'h00);
    run(8'h0A, 3'd1);
    chk(result == 3'd4, "R6 reset on change result", result, 4);
    chk(readCnt == 9, "R6 reset on change reads", readCnt, 9);
  endtask

  task automatic t_eq_fail();
    prep();
    statTab[0] = st(8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
    statTab[1] = st(8'h03, 8'h00, 8'h01, 8'h00, 8'h00);
    for (int i = 2; i < 16; i++) statTab[i] = st(8'h07, 8'h00, 8'h00, 8'h00, 8'h00);
    run(8'h0A, 3'd1);
    chk(result == 3'd5, "R8 eq fail", result, 5);
    chk(readCnt == 6, "R8 eq read limit", readCnt, 6);
  endtask

  task automatic t_aux_err();
    prep();
    errAt = 2;
    run(8'h0A, 3'd2);
    chk(result == 3'd3, "R9 aux error", result, 3);
    chk(reqCnt == 3, "R9 no more requests", reqCnt, 3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_cfg();
    t_happy();
    t_merge();
    t_max_swing();
    t_retry();
    t_eq_fail();
    t_aux_err();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule